// File: doc/BRIEF.md
# Luminance Processor Control Port (I2C Slave, Two Registers)

This block is the serial control port of a video luminance processor. An I2C master addresses it at the 7-bit slave address `1000100`. In a write, the master sends a subaddress byte and then one or more data bytes. The data bytes land in two 8-bit control registers, and the internal pointer steps forward after each accepted byte. In a read, the slave returns register contents as a transmitter, starting at the current pointer.

The register fields are decoded continuously and presented as parallel outputs. Two of these outputs are arithmetic conversions:
- the luminance delay total in nanoseconds, computed from the five delay-section select bits;
- the signed peaking gain in dB, computed from the 4-bit peaking code.

Both bus lines are brought into the system clock domain through a two-flop synchroniser. SDA is driven open-drain: `sda_oe` high pulls the line low.

Top module: `lumactl_i2c_port`

## Requirements
- R1: After reset both registers hold 0x01, so dly_sel is 1, delay_ns is 45, pk_code is 1 and peak_db is +8, with every other field 0 and SDA released.
- R2: An address byte whose upper seven bits are 1000100 is acknowledged, and its bit 0 selects write (0) or read (1). Any other address, the general call 0x00 included, is not acknowledged, and the rest of that transfer is ignored until the next START or STOP.
- R3: The byte after a write address sets the pointer and is acknowledged only when it is 0x10 or 0x11. After any other value, every data byte of that transfer is not acknowledged and changes no register.
- R4: A data byte is acknowledged and written to the register at the pointer when the pointer is 0x10 or 0x11, and the pointer then increments by one.
- R5: A data byte that arrives after auto-increment has moved the pointer past 0x11 is not acknowledged and is discarded.
- R6: Some bits always read and decode as 0, whatever value is written: bits 7 and 5 of register 0x10, and bit 4 of register 0x11.
- R7: Register 0x10 decodes as follows. Bit 6 drives sc_5v (1 selects the 5 V level). Bits 4..0 drive dly_sel. delay_ns equals 45·b0 + 90·b1 + 180·b2 + 180·b3 + 450·b4.
- R8: Register 0x11 decodes as follows:
  - bit 7 drives cor_en;
  - bit 6 drives pk_dly_en;
  - bit 5 drives low_fc (1 selects the 2.6 MHz centre);
  - bits 3..0 drive pk_code.
  peak_db equals 9 minus the code, covering +9 dB for code 0 down to -6 dB for code 15.
- R9: In a read, each byte comes from the register at the pointer (0xFF if the pointer is outside 0x10..0x11) and is sent MSB first. The pointer increments after every byte. A master ACK continues the read; a master NACK leaves SDA released.
- R10: sda_oe rises only while SCL is low.
- R11: A START at any point restarts address reception, so a repeated START may turn a write into a read. A STOP in the middle of a byte abandons it without changing any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as sensed |
| sda_i | input | 1 | I2C data line as sensed |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sc_5v | output | 1 | Sandcastle level select, 1 = 5 V |
| dly_sel | output | 5 | Delay section selects |
| delay_ns | output | 11 | Total selected luminance delay in ns |
| cor_en | output | 1 | Coring enable |
| pk_dly_en | output | 1 | Peaking delay enable |
| low_fc | output | 1 | Low peaking centre frequency select |
| pk_code | output | 4 | Raw peaking code |
| peak_db | output | 5 | Signed peaking gain in dB |

## Verification
Some properties are checked by assertions on every cycle:
- the fixed-zero register bits stay zero;
- a register write is only ever requested for an in-range subaddress;
- the registers hold still when no write is requested;
- the slave never pulls SDA while idle or ignoring a transfer;
- sda_oe rises only while SCL is low.

Other behaviours only the bench scenarios can show:
- acknowledge decisions for matching, foreign and general-call addresses;
- auto-increment across and past the register pair;
- read data order and the return value for an unmapped pointer;
- repeated-START turnaround and the abandoned-byte STOP;
- the full sweeps of the delay sum and the peaking gain.

// File: rtl/lc_pkg.sv
package lc_pkg;

  localparam int DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WR,
    ST_RD,
    ST_ACK,
    ST_MACK,
    ST_SKIP
  } lc_state_t;

  typedef struct packed {
    logic       sc_5v;
    logic [4:0] dly_sel;
  } lc_timing_t;

  typedef struct packed {
    logic       cor_en;
    logic       pk_dly_en;
    logic       low_fc;
    logic [3:0] pk_code;
  } lc_peak_t;

  // True when addr lies inside the window of n registers starting at base.
  function automatic logic lc_in_range(input logic [7:0] addr,
                                       input logic [7:0] base,
                                       input int n);
    return (addr >= base) && (int'(addr) < int'(base) + n);
  endfunction

  // Bits that a register can hold; the rest are forced to zero.
  function automatic logic [7:0] lc_keep_mask(input int idx);
    case (idx)
      0:       return 8'b0101_1111;
      1:       return 8'b1110_1111;
      default: return 8'hFF;
    endcase
  endfunction

  // Sum of the selected delay sections in ns.
  function automatic logic [10:0] lc_delay_ns(input logic [4:0] sel);
    logic [10:0] s;
    s = 11'd0;
    if (sel[0]) s = s + 11'd45;
    if (sel[1]) s = s + 11'd90;
    if (sel[2]) s = s + 11'd180;
    if (sel[3]) s = s + 11'd180;
    if (sel[4]) s = s + 11'd450;
    return s;
  endfunction

  // Peaking gain in dB: code 0 is +9, each code step lowers it by 1.
  function automatic logic signed [4:0] lc_peak_db(input logic [3:0] code);
    return 5'sd9 - $signed({1'b0, code});
  endfunction

endpackage

// File: rtl/lc_sync.sv
module lc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_sr, sda_sr;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_sr[STAGES-1];
      sda_q  <= sda_sr[STAGES-1];
    end
  end

  assign scl_s    = scl_sr[STAGES-1];
  assign sda_s    = sda_sr[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/lc_i2c_fsm.sv
module lc_i2c_fsm
  import lc_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'b1000100,
  parameter logic [7:0] BASE  = 8'h10,
  parameter int         NREG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe
);

  lc_state_t   state, nxt;
  logic [1:0]  ph;
  logic [2:0]  cnt;
  logic [7:0]  sh;
  logic        ack_flag;

  // Named internal events
  logic [7:0]  byte_in;
  logic        rx_state;
  logic        byte_done;
  logic        addr_hit;
  logic        sub_ok;
  logic        ptr_ok;

  assign byte_in   = {sh[6:0], sda_s};
  assign rx_state  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_WR);
  assign byte_done = rx_state && scl_rise && (cnt == 3'd7);
  assign addr_hit  = (byte_in[7:1] == ADDR7);
  assign sub_ok    = lc_in_range(byte_in, BASE, NREG);
  assign ptr_ok    = lc_in_range(ptr, BASE, NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      ph       <= 2'd0;
      cnt      <= 3'd0;
      sh       <= 8'd0;
      ack_flag <= 1'b0;
      ptr      <= BASE;
      wr_en    <= 1'b0;
      wr_addr  <= 8'd0;
      wr_data  <= 8'd0;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        cnt    <= 3'd0;
        ph     <= 2'd0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WR: begin
            if (scl_rise) begin
              sh  <= byte_in;
              cnt <= cnt + 3'd1;
            end
            if (byte_done) begin
              state <= ST_ACK;
              ph    <= 2'd0;
              if (state == ST_ADDR) begin
                ack_flag <= addr_hit;
                nxt      <= !addr_hit ? ST_SKIP : (byte_in[0] ? ST_RD : ST_SUB);
              end else if (state == ST_SUB) begin
                ptr      <= byte_in;
                ack_flag <= sub_ok;
                nxt      <= ST_WR;
              end else begin
                ack_flag <= ptr_ok;
                nxt      <= ST_WR;
                if (ptr_ok) begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= byte_in;
                  ptr     <= ptr + 8'd1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ph == 2'd0) begin
                sda_oe <= ack_flag;
                ph     <= 2'd1;
              end else begin
                ph    <= 2'd0;
                cnt   <= 3'd0;
                state <= nxt;
                if (nxt == ST_RD) begin
                  sh     <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                state <= ST_MACK;
                ph    <= 2'd0;
                ptr   <= ptr + 8'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_fall && ph == 2'd0) begin
              sda_oe <= 1'b0;
              ph     <= 2'd1;
            end else if (scl_rise && ph == 2'd1) begin
              if (!sda_s) ph <= 2'd2;
              else        state <= ST_SKIP;
            end else if (scl_fall && ph == 2'd2) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              cnt    <= 3'd0;
              ph     <= 2'd0;
              state  <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: the slave only starts pulling SDA while SCL is low
  a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R2: no drive while idle or ignoring a foreign transfer
  a_r2_quiet_when_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe);

endmodule

// File: rtl/lc_regfile.sv
module lc_regfile
  import lc_pkg::*;
#(
  parameter logic [7:0] BASE    = 8'h10,
  parameter int         NREG    = 2,
  parameter logic [7:0] RST_VAL = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] ADR  = BASE + 8'(g);
    localparam logic [7:0] KEEP = lc_keep_mask(g);
    logic [7:0] r_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            r_q <= RST_VAL & KEEP;
      else if (wr_en && (wr_addr == ADR))    r_q <= wr_data & KEEP;
    end

    assign regs_flat[g*8 +: 8] = r_q;

    // R6: bits outside the keep mask never hold a one
    a_r6_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (r_q & ~KEEP) == 8'd0);
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == BASE + 8'(i)) rd_data = regs_flat[i*8 +: 8];
    end
  end

  // R3: the protocol side only requests writes inside the register window
  a_r3_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> lc_in_range(wr_addr, BASE, NREG));

  // R4: registers change only on a write request
  a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

endmodule

// File: rtl/lumactl_i2c_port.sv
module lumactl_i2c_port
  import lc_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'b1000100,
  parameter logic [7:0] BASE        = 8'h10,
  parameter int         NREG        = 2,
  parameter logic [7:0] RST_VAL     = 8'h01,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              sc_5v,
  output logic [4:0]        dly_sel,
  output logic [10:0]       delay_ns,
  output logic              cor_en,
  output logic              pk_dly_en,
  output logic              low_fc,
  output logic [3:0]        pk_code,
  output logic signed [4:0] peak_db
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0] ptr, wr_addr, wr_data, rd_data;
  logic       wr_en;
  logic [NREG*8-1:0] regs_flat;
  lc_timing_t tim;
  lc_peak_t   pk;

  lc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  lc_i2c_fsm #(.ADDR7(ADDR7), .BASE(BASE), .NREG(NREG)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  lc_regfile #(.BASE(BASE), .NREG(NREG), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  // Field decode of the timing and peaking registers
  assign tim = '{sc_5v: regs_flat[6], dly_sel: regs_flat[4:0]};
  assign pk  = '{cor_en: regs_flat[15], pk_dly_en: regs_flat[14],
                 low_fc: regs_flat[13], pk_code: regs_flat[11:8]};

  assign sc_5v     = tim.sc_5v;
  assign dly_sel   = tim.dly_sel;
  assign delay_ns  = lc_delay_ns(tim.dly_sel);
  assign cor_en    = pk.cor_en;
  assign pk_dly_en = pk.pk_dly_en;
  assign low_fc    = pk.low_fc;
  assign pk_code   = pk.pk_code;
  assign peak_db   = lc_peak_db(pk.pk_code);

endmodule

// File: tb/sim_lumactl_i2c_port.sv
`timescale 1ns/1ps
module sim_lumactl_i2c_port;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  wire  sda_line;
  logic sda_oe, sc_5v, cor_en, pk_dly_en, low_fc;
  logic [4:0] dly_sel;
  logic [10:0] delay_ns;
  logic [3:0] pk_code;
  logic signed [4:0] peak_db;

  always #10 clk = ~clk;   // 50 MHz

  assign sda_line = sda_m & ~sda_oe;

  lumactl_i2c_port u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .sc_5v(sc_5v), .dly_sel(dly_sel), .delay_ns(delay_ns), .cor_en(cor_en),
    .pk_dly_en(pk_dly_en), .low_fc(low_fc), .pk_code(pk_code), .peak_db(peak_db)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit live = 1'b0;
  int mreg [2];
  int mptr = 16;
  bit prev_oe = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_delay(input int v);
    int w [5] = '{45, 90, 180, 180, 450};
    int s = 0;
    for (int k = 0; k < 5; k++) if ((v >> k) & 1) s += w[k];
    return s;
  endfunction

  function automatic int m_db(input int code);
    if (code < 8) return 9 - code;
    return 1 - (code - 8);
  endfunction

  function automatic bit m_hit(input int p);
    return (p == 16) || (p == 17);
  endfunction

  // Reference comparison of every decoded field on every clock
  always @(negedge clk) begin
    if (rst_n && live) begin
      int r0, r1;
      bit ok;
      r0 = mreg[0]; r1 = mreg[1];
      ok = (sc_5v == r0[6]) && (int'(dly_sel) == (r0 & 31)) &&
           (int'(delay_ns) == m_delay(r0 & 31)) && (cor_en == r1[7]) &&
           (pk_dly_en == r1[6]) && (low_fc == r1[5]) &&
           (int'(pk_code) == (r1 & 15)) && (int'(peak_db) == m_db(r1 & 15));
      chk(ok, "R7 R8 field decode", {dly_sel, pk_code}, {r0[4:0], r1[3:0]});
    end
    if (rst_n && sda_oe && !prev_oe)
      chk(!scl, "R10 oe rise with SCL low", scl, 0);
    prev_oe = sda_oe;
  end

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tk(4); scl = 1'b1; tk(8); sda_m = 1'b0; tk(8); scl = 1'b0; tk(4);
  endtask

  task automatic i2c_stop;
    tk(4); sda_m = 1'b0; tk(4); scl = 1'b1; tk(8); sda_m = 1'b1; tk(8);
  endtask

  task automatic send_bit(input bit b);
    tk(4); sda_m = b; tk(4); scl = 1'b1; tk(8); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    tk(4); sda_m = 1'b1; tk(4); scl = 1'b1; tk(4); ack = !sda_line; tk(4); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tk(8); scl = 1'b1; tk(4); b[i] = sda_line; tk(4); scl = 1'b0;
    end
    tk(4); sda_m = !mack; tk(4); scl = 1'b1; tk(8); scl = 1'b0; tk(4); sda_m = 1'b1;
  endtask

  function automatic int m_mask(input int idx, input int d);
    return (idx == 0) ? (d & 8'h5F) : (d & 8'hEF);
  endfunction

  // Write transfer: addr byte, subaddress, n data bytes (byte k at d[8k+:8])
  task automatic wr_tx(input logic [7:0] ab, input logic [7:0] sb, input int n,
                       input logic [31:0] d);
    bit a, e;
    live = 1'b0;
    i2c_start;
    send_byte(ab, a);
    e = (ab[7:1] == 7'b1000100) && !ab[0];
    chk(a == e, "R2 address ack", a, e);
    if (!a) begin
      send_byte(sb, a);
      chk(a == 1'b0, "R2 ignored after nack", a, 0);
      i2c_stop; live = 1'b1;
      return;
    end
    send_byte(sb, a);
    e = m_hit(sb);
    chk(a == e, "R3 subaddress ack", a, e);
    mptr = sb;
    for (int k = 0; k < n; k++) begin
      send_byte(d[8*k +: 8], a);
      e = m_hit(mptr);
      if (e) chk(a == e, "R4 data ack", a, e);
      else if (mptr > 17) chk(a == e, "R5 past window nack", a, e);
      else chk(a == e, "R3 data nack after bad subaddress", a, e);
      if (e) begin
        mreg[mptr - 16] = m_mask(mptr - 16, d[8*k +: 8]);
        mptr++;
      end
    end
    i2c_stop;
    live = 1'b1;
  endtask

  // Read transfer, optionally setting the pointer first and turning round with a repeated START
  task automatic rd_tx(input bit set_sub, input logic [7:0] sb, input int n);
    bit a;
    logic [7:0] b;
    int e;
    i2c_start;
    if (set_sub) begin
      send_byte(8'h88, a); chk(a, "R2 write address ack", a, 1);
      send_byte(sb, a);    mptr = sb;
      i2c_start;           // R11 repeated START
    end
    send_byte(8'h89, a);
    chk(a, "R11 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      e = m_hit(mptr) ? mreg[mptr - 16] : 255;
      chk(int'(b) == e, "R9 read data", b, e);
      mptr++;
    end
    tk(2);
    chk(sda_oe == 1'b0, "R9 release after master nack", sda_oe, 0);
    i2c_stop;
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run;
  end

  initial begin
    bit a;
    tk(10); rst_n = 1'b1; tk(10);
    // R1 reset state
    chk(dly_sel == 5'd1, "R1 dly_sel", dly_sel, 1);
    chk(delay_ns == 11'd45, "R1 delay_ns", delay_ns, 45);
    chk(pk_code == 4'd1, "R1 pk_code", pk_code, 1);
    chk(int'(peak_db) == 8, "R1 peak_db", peak_db, 8);
    chk({sc_5v, cor_en, pk_dly_en, low_fc} == 4'd0, "R1 flags", {sc_5v, cor_en, pk_dly_en, low_fc}, 0);
    chk(sda_oe == 1'b0, "R1 SDA released", sda_oe, 0);
    mreg[0] = 1; mreg[1] = 1; live = 1'b1;

    // R4 auto-increment across both registers
    wr_tx(8'h88, 8'h10, 2, {16'h0, 8'hA3, 8'h5A});
    // R6 fixed-zero bits
    wr_tx(8'h88, 8'h10, 2, {16'h0, 8'hFF, 8'hFF});
    chk(delay_ns == 11'd945, "R7 full delay", delay_ns, 945);
    chk(int'(peak_db) == -6, "R8 lowest gain", peak_db, -6);
    rd_tx(1'b1, 8'h10, 3);   // R9 reads 0x5F, 0xEF, 0xFF
    // R3 reserved subaddress
    wr_tx(8'h88, 8'h0F, 1, {24'h0, 8'h00});
    // R5 auto-increment past 0x11
    wr_tx(8'h88, 8'h11, 2, {16'h0, 8'h77, 8'h20});
    // R2 foreign address and general call
    wr_tx(8'h90, 8'h10, 0, 32'h0);
    wr_tx(8'h00, 8'h10, 0, 32'h0);
    // R11 STOP in the middle of a data byte
    live = 1'b0;
    i2c_start; send_byte(8'h88, a); send_byte(8'h10, a); mptr = 16;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop; live = 1'b1; tk(4);
    chk(int'(dly_sel) == (mreg[0] & 31), "R11 abandoned byte", dly_sel, mreg[0] & 31);
    rd_tx(1'b0, 8'h00, 2);   // R9 read at current pointer
    // R8 peaking code sweep
    for (int c = 0; c < 16; c++) begin
      wr_tx(8'h88, 8'h11, 1, {24'h0, 8'(c | 8'hA0)});
      chk(int'(peak_db) == m_db(c), "R8 peak_db", peak_db, m_db(c));
    end
    // R7 delay sweep with 5 V sandcastle level
    for (int v = 0; v < 32; v++) begin
      wr_tx(8'h88, 8'h10, 1, {24'h0, 8'(v | 8'h40)});
      chk(int'(delay_ns) == m_delay(v), "R7 delay_ns", delay_ns, m_delay(v));
      chk(sc_5v == 1'b1, "R7 sc_5v", sc_5v, 1);
    end
    tk(20);
    finish_run;
  end

endmodule